// File: doc/BRIEF.md
# Slot-Based Tagged Cell Concentration Arbiter

This block is the arbitration stage of a concentration module. A number of dispatch controllers each own a small group of one-cell buffers. Every buffer holds at most one cell, and that cell carries a sequence tag assigned by its controller. The arbiter owns the round-robin port rank of every controller and drives these ranks back to the controllers. Within one slot it lets through at most one cell per output link. The cells it picks are those with the smallest combined tag, formed as {port rank, sequence tag}, so the port rank is the more significant part.

A single-cycle slot strobe starts a slot. On that strobe the arbiter registers a snapshot of all buffer valid bits, tags and payloads. It then runs one minimum search per output link, one per clock, over the buffers that are still left. When the searches are done it publishes the winners on the output links in ascending tag order. In the same cycle it pulses a clear to every granted buffer and advances the rank rotation. Because of this, the controller ranked highest in a slot always drains completely. A lower-ranked controller gives up its cells lowest sequence first, which keeps every controller's cells in order.

Top module: `cm_arbiter`

## Requirements
- R1: A rising slot strobe seen while idle registers the buffer valid bits, tags and payloads. Input changes after that edge do not alter the slot's result.
- R2: A cell's combined key is the controller's port rank followed by its SEQ_W-bit sequence tag, with the rank in the high bits. A smaller key wins.
- R3: At most LINKS buffers are granted per slot. The controller at rank 0 has every occupied buffer granted.
- R4: Buffers whose valid bit is low never win. When fewer than LINKS buffers are occupied, all of them are granted and the extra links show outValid low.
- R5: If two buffers have equal keys, the one with the lower flat index (controller × LINKS + buffer) wins first.
- R6: Winners appear on links 0 upward in ascending key order, so the valid bits are packed from link 0. Link outputs hold until the next publish.
- R7: If the strobe is sampled at edge E0, then at edge E0+LINKS+1 bufClear goes high for exactly the granted buffers. It lasts one cycle. Ungranted buffers see no clear.
- R8: After reset, controller j has rank j. Each publish moves the head forward by one, so that controller j's rank becomes (j − head) mod NUM_CTRL. Ranks stay stable between publishes.
- R9: A slot strobe that arrives while a slot is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slotStart | input | 1 | Slot strobe, one cycle wide |
| bufValid | input | NUM_CTRL*LINKS | Buffer occupied, bit k = controller k/LINKS, buffer k%LINKS |
| bufSeq | input | NUM_CTRL*LINKS*SEQ_W | Sequence tag of buffer k at [k*SEQ_W +: SEQ_W] |
| bufData | input | NUM_CTRL*LINKS*DATA_W | Payload of buffer k at [k*DATA_W +: DATA_W] |
| bufClear | output | NUM_CTRL*LINKS | One-cycle clear to granted buffers |
| portPrio | output | NUM_CTRL*PORT_W | Rank of controller j at [j*PORT_W +: PORT_W] |
| outValid | output | LINKS | Output link carries a cell |
| outData | output | LINKS*DATA_W | Payload on link m at [m*DATA_W +: DATA_W] |

## Verification
Some properties are checked by assertions on every cycle. The clear is a single pulse, and no slot grants more than LINKS buffers. The number of valid links equals the number of cleared buffers. Valid links are packed from link 0. The ranks always form a permutation and change only by one rotation step per publish. Which buffers win, whether the rank-0 controller drains fully, the tie order, the payload order on the links, immunity to inputs changed after capture, and the ignoring of strobes during a slot can only be shown by the bench. It does this by comparing each slot against an arithmetic model across many occupancy and tag patterns.

// File: rtl/cm_arbiter_pkg.sv
package cm_arbiter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PUB  = 2'd2
  } arbState_t;

  typedef struct packed {
    logic capture;
    logic step;
    logic publish;
  } arbStrobe_t;

endpackage

// File: rtl/cm_arbiter_ctrl.sv
module cm_arbiter_ctrl
  import cm_arbiter_pkg::*;
#(
  parameter int LINKS  = 4,
  parameter int STEP_W = (LINKS > 1) ? $clog2(LINKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStart,
  output arbStrobe_t        strb,
  output logic [STEP_W-1:0] stepIdx
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LINKS - 1);

  arbState_t         state;
  arbState_t         stateNext;
  logic [STEP_W-1:0] stepCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (slotStart) stateNext = ST_RUN;
      ST_RUN:  if (stepCnt == LAST_STEP) stateNext = ST_PUB;
      ST_PUB:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_RUN) stepCnt <= stepCnt + STEP_W'(1);
      else                 stepCnt <= '0;
    end
  end

  always_comb begin
    strb.capture = (state == ST_IDLE) && slotStart;
    strb.step    = (state == ST_RUN);
    strb.publish = (state == ST_PUB);
    stepIdx      = stepCnt;
  end

endmodule

// File: rtl/cm_min_finder.sv
module cm_min_finder #(
  parameter int N     = 12,
  parameter int KEY_W = 6,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]       cand,
  input  logic [N*KEY_W-1:0] keys,
  output logic               found,
  output logic [IDX_W-1:0]   bestIdx
);

  logic [KEY_W-1:0] bestKey;

  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestKey = '0;
    for (int k = 0; k < N; k++) begin
      if (cand[k] && (!found || (keys[k*KEY_W +: KEY_W] < bestKey))) begin
        found   = 1'b1;
        bestKey = keys[k*KEY_W +: KEY_W];
        bestIdx = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/cm_arbiter_dp.sv
module cm_arbiter_dp
  import cm_arbiter_pkg::*;
#(
  parameter int NUM_CTRL = 3,
  parameter int LINKS    = 4,
  parameter int SEQ_W    = 4,
  parameter int DATA_W   = 8,
  parameter int PORT_W   = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
  parameter int STEP_W   = (LINKS > 1) ? $clog2(LINKS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  arbStrobe_t                   strb,
  input  logic [STEP_W-1:0]            stepIdx,
  input  logic [NUM_CTRL*LINKS-1:0]    bufValid,
  input  logic [NUM_CTRL*LINKS*SEQ_W-1:0]  bufSeq,
  input  logic [NUM_CTRL*LINKS*DATA_W-1:0] bufData,
  output logic [NUM_CTRL*LINKS-1:0]    bufClear,
  output logic [NUM_CTRL*PORT_W-1:0]   portPrio,
  output logic [LINKS-1:0]             outValid,
  output logic [LINKS*DATA_W-1:0]      outData
);

  localparam int N     = NUM_CTRL * LINKS;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int KEY_W = PORT_W + SEQ_W;

  // registered slot snapshot
  logic [N-1:0]       snapValid;
  logic [SEQ_W-1:0]   snapSeq  [N];
  logic [DATA_W-1:0]  snapData [N];
  logic [N-1:0]       taken;

  // per-link picks
  logic [IDX_W-1:0]   pickIdx [LINKS];
  logic [LINKS-1:0]   pickOk;

  // round-robin head and ranks
  logic [PORT_W-1:0]  head;
  logic [PORT_W-1:0]  rankOf [NUM_CTRL];

  logic [N*KEY_W-1:0] keyVec;
  logic [N-1:0]       candVec;
  logic               minFound;
  logic [IDX_W-1:0]   minIdx;

  always_comb begin
    for (int j = 0; j < NUM_CTRL; j++) begin
      int r;
      r = j - int'(head);
      if (r < 0) r = r + NUM_CTRL;
      rankOf[j] = PORT_W'(r);
    end
  end

  for (genvar j = 0; j < NUM_CTRL; j++) begin : g_ctrl
    assign portPrio[j*PORT_W +: PORT_W] = rankOf[j];
    for (genvar m = 0; m < LINKS; m++) begin : g_buf
      localparam int K = j * LINKS + m;
      assign keyVec[K*KEY_W +: KEY_W] = {rankOf[j], snapSeq[K]};
    end
  end

  assign candVec = snapValid & ~taken;

  cm_min_finder #(
    .N    (N),
    .KEY_W(KEY_W),
    .IDX_W(IDX_W)
  ) u_min (
    .cand   (candVec),
    .keys   (keyVec),
    .found  (minFound),
    .bestIdx(minIdx)
  );

  // snapshot capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapValid <= '0;
      for (int k = 0; k < N; k++) begin
        snapSeq[k]  <= '0;
        snapData[k] <= '0;
      end
    end else if (strb.capture) begin
      snapValid <= bufValid;
      for (int k = 0; k < N; k++) begin
        snapSeq[k]  <= bufSeq[k*SEQ_W +: SEQ_W];
        snapData[k] <= bufData[k*DATA_W +: DATA_W];
      end
    end
  end

  // iterated minimum search, one link per step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taken  <= '0;
      pickOk <= '0;
      for (int m = 0; m < LINKS; m++) pickIdx[m] <= '0;
    end else if (strb.capture) begin
      taken  <= '0;
      pickOk <= '0;
    end else if (strb.step) begin
      pickOk[stepIdx]  <= minFound;
      pickIdx[stepIdx] <= minIdx;
      if (minFound) taken[minIdx] <= 1'b1;
    end
  end

  // publish: outputs, clear pulse, rank rotation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufClear <= '0;
      outValid <= '0;
      outData  <= '0;
      head     <= '0;
    end else begin
      bufClear <= '0;
      if (strb.publish) begin
        bufClear <= taken;
        outValid <= pickOk;
        for (int m = 0; m < LINKS; m++) begin
          outData[m*DATA_W +: DATA_W] <= pickOk[m] ? snapData[pickIdx[m]] : '0;
        end
        if (int'(head) == NUM_CTRL - 1) head <= '0;
        else                            head <= head + PORT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cm_arbiter.sv
module cm_arbiter
  import cm_arbiter_pkg::*;
#(
  parameter int NUM_CTRL = 3,
  parameter int LINKS    = 4,
  parameter int SEQ_W    = 4,
  parameter int DATA_W   = 8,
  parameter int PORT_W   = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             slotStart,
  input  logic [NUM_CTRL*LINKS-1:0]        bufValid,
  input  logic [NUM_CTRL*LINKS*SEQ_W-1:0]  bufSeq,
  input  logic [NUM_CTRL*LINKS*DATA_W-1:0] bufData,
  output logic [NUM_CTRL*LINKS-1:0]        bufClear,
  output logic [NUM_CTRL*PORT_W-1:0]       portPrio,
  output logic [LINKS-1:0]                 outValid,
  output logic [LINKS*DATA_W-1:0]          outData
);

  localparam int STEP_W = (LINKS > 1) ? $clog2(LINKS) : 1;

  arbStrobe_t        strb;
  logic [STEP_W-1:0] stepIdx;
  logic              pubStrobe;

  assign pubStrobe = strb.publish;

  cm_arbiter_ctrl #(
    .LINKS (LINKS),
    .STEP_W(STEP_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotStart(slotStart),
    .strb     (strb),
    .stepIdx  (stepIdx)
  );

  cm_arbiter_dp #(
    .NUM_CTRL(NUM_CTRL),
    .LINKS   (LINKS),
    .SEQ_W   (SEQ_W),
    .DATA_W  (DATA_W),
    .PORT_W  (PORT_W),
    .STEP_W  (STEP_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .stepIdx (stepIdx),
    .bufValid(bufValid),
    .bufSeq  (bufSeq),
    .bufData (bufData),
    .bufClear(bufClear),
    .portPrio(portPrio),
    .outValid(outValid),
    .outData (outData)
  );

endmodule

// File: rtl/cm_arbiter_checker.sv
module cm_arbiter_checker #(
  parameter int NUM_CTRL = 3,
  parameter int LINKS    = 4,
  parameter int PORT_W   = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pubStrobe,
  input logic [NUM_CTRL*LINKS-1:0]  bufClear,
  input logic [NUM_CTRL*PORT_W-1:0] portPrio,
  input logic [LINKS-1:0]           outValid
);

  logic [PORT_W-1:0]   rankZero;
  logic [NUM_CTRL-1:0] rankSeen;

  assign rankZero = portPrio[PORT_W-1:0];

  always_comb begin
    rankSeen = '0;
    for (int j = 0; j < NUM_CTRL; j++) begin
      if (int'(portPrio[j*PORT_W +: PORT_W]) < NUM_CTRL)
        rankSeen[int'(portPrio[j*PORT_W +: PORT_W])] = 1'b1;
    end
  end

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (bufClear != '0) |=> (bufClear == '0)); // R7

  AST_GRANT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(bufClear) <= LINKS); // R3

  AST_LINKS_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (bufClear != '0) |-> ($countones(outValid) == $countones(bufClear))); // R4

  AST_LINKS_PACKED: assert property (@(posedge clk) disable iff (!rstN)
    ((outValid & (outValid + 1'b1)) == '0)); // R6

  AST_RANKS_PERMUTE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rankSeen) == NUM_CTRL); // R8

  AST_RANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pubStrobe |=> $stable(portPrio)); // R8

  AST_RANK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pubStrobe |=> (int'(rankZero) == ((int'($past(rankZero)) + NUM_CTRL - 1) % NUM_CTRL))); // R8

endmodule

bind cm_arbiter cm_arbiter_checker #(
  .NUM_CTRL(NUM_CTRL),
  .LINKS   (LINKS),
  .PORT_W  (PORT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pubStrobe(pubStrobe),
  .bufClear (bufClear),
  .portPrio (portPrio),
  .outValid (outValid)
);

// File: tb/cm_arbiter_test.sv
`timescale 1ns/1ps
module cm_arbiter_test;

  localparam int J      = 3;
  localparam int M      = 4;
  localparam int SEQ_W  = 4;
  localparam int DATA_W = 8;
  localparam int PORT_W = 2;
  localparam int N      = J * M;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slotStart = 1'b0;
  logic [N-1:0]        bufValid = '0;
  logic [N*SEQ_W-1:0]  bufSeq = '0;
  logic [N*DATA_W-1:0] bufData = '0;
  logic [N-1:0]        bufClear;
  logic [J*PORT_W-1:0] portPrio;
  logic [M-1:0]        outValid;
  logic [M*DATA_W-1:0] outData;

  int testsRun = 0;
  int testsFailed = 0;
  int expHead = 0;
  bit finished = 0;

  // saved stimulus for the model
  logic [N-1:0]        sV;
  logic [N*SEQ_W-1:0]  sS;
  logic [N*DATA_W-1:0] sD;
  logic [N-1:0]        eClr;
  logic [M-1:0]        eOutV;
  logic [M*DATA_W-1:0] eOutD;

  always #10 clk = ~clk;

  cm_arbiter #(.NUM_CTRL(J), .LINKS(M), .SEQ_W(SEQ_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .slotStart(slotStart),
    .bufValid(bufValid), .bufSeq(bufSeq), .bufData(bufData),
    .bufClear(bufClear), .portPrio(portPrio),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rankOf(input int c, input int hd);
    return (c - hd + J) % J;
  endfunction

  // R2/R4/R5/R6 model: iterated smallest key, lower index on ties
  task automatic model();
    logic [N-1:0] tk;
    tk = '0;
    eClr = '0; eOutV = '0; eOutD = '0;
    for (int m = 0; m < M; m++) begin
      int best;
      int bestKey;
      best = -1; bestKey = 0;
      for (int k = 0; k < N; k++) begin
        int key;
        key = rankOf(k / M, expHead) * (1 << SEQ_W) + int'(sS[k*SEQ_W +: SEQ_W]);
        if (sV[k] && !tk[k] && (best < 0 || key < bestKey)) begin
          best = k; bestKey = key;
        end
      end
      if (best >= 0) begin
        tk[best] = 1'b1;
        eOutV[m] = 1'b1;
        eOutD[m*DATA_W +: DATA_W] = sD[best*DATA_W +: DATA_W];
      end
    end
    eClr = tk;
  endtask

  task automatic checkRanks(input string req);
    for (int j = 0; j < J; j++) begin
      check(int'(portPrio[j*PORT_W +: PORT_W]) == rankOf(j, expHead), req, "portPrio",
            64'(portPrio[j*PORT_W +: PORT_W]), 64'(rankOf(j, expHead)));
    end
  endtask

  task automatic runSlot(input logic [N-1:0] v, input logic [N*SEQ_W-1:0] s,
                         input logic [N*DATA_W-1:0] d, input bit busyPoke,
                         input string req);
    int topCtrl;
    @(negedge clk);
    bufValid = v; bufSeq = s; bufData = d;
    sV = v; sS = s; sD = d;
    model();
    topCtrl = expHead;
    slotStart = 1'b1;
    @(posedge clk);                         // E0 capture
    @(negedge clk);
    slotStart = 1'b0;
    // R1: scramble inputs after capture
    bufValid = N'($urandom); bufSeq = (N*SEQ_W)'({$urandom, $urandom});
    bufData = (N*DATA_W)'({$urandom, $urandom, $urandom});
    if (busyPoke) begin
      slotStart = 1'b1;                     // R9: strobe while busy
      @(posedge clk);
      @(negedge clk);
      slotStart = 1'b0;
      repeat (M) @(posedge clk);
    end else begin
      repeat (M + 1) @(posedge clk);
    end
    @(negedge clk);                         // after E0+M+1
    check(bufClear == eClr, req, "R7 clear vector", 64'(bufClear), 64'(eClr));
    check(outValid == eOutV, req, "R4 link valid", 64'(outValid), 64'(eOutV));
    check(outData == eOutD, req, "R6 link data", 64'(outData), 64'(eOutD));
    check((bufClear[topCtrl*M +: M] & sV[topCtrl*M +: M]) == sV[topCtrl*M +: M],
          "R3", "rank0 drained", 64'(bufClear[topCtrl*M +: M]), 64'(sV[topCtrl*M +: M]));
    expHead = (expHead + 1) % J;
    checkRanks("R8");
    @(negedge clk);
    check(bufClear == '0, "R7", "clear dropped", 64'(bufClear), 64'd0);
    check(outData == eOutD && outValid == eOutV, "R6", "links held",
          64'(outData), 64'(eOutD));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0]        v;
    logic [N*SEQ_W-1:0]  s;
    logic [N*DATA_W-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bufClear == '0, "R7", "reset clear", 64'(bufClear), 64'd0);
    check(outValid == '0, "R4", "reset links", 64'(outValid), 64'd0);
    checkRanks("R8");
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < N; k++) d[k*DATA_W +: DATA_W] = DATA_W'(8'hA0 + k);

    // empty: nothing granted (R4)
    runSlot('0, '0, d, 1'b0, "R4");

    // rank-0 full with seq 0..3, rank-1 empty, rank-2 one cell (R2, R3)
    for (int rep = 0; rep < J; rep++) begin
      v = '0; s = '0;
      for (int m = 0; m < M; m++) begin
        v[expHead*M + m] = 1'b1;
        s[(expHead*M + m)*SEQ_W +: SEQ_W] = SEQ_W'(M - 1 - m);
      end
      v[((expHead + 2) % J)*M] = 1'b1;
      runSlot(v, s, d, 1'b0, "R2");
    end

    // partial drain: rank-0 two cells, rank-1 all four in scrambled order (R2, R6)
    v = '0; s = '0;
    v[expHead*M +: 2] = 2'b11;
    for (int m = 0; m < M; m++) begin
      v[((expHead + 1) % J)*M + m] = 1'b1;
      s[(((expHead + 1) % J)*M + m)*SEQ_W +: SEQ_W] = SEQ_W'((m * 3) % M + 2);
    end
    runSlot(v, s, d, 1'b0, "R6");

    // ties: all occupied, equal tags (R5)
    runSlot('1, '0, d, 1'b0, "R5");
    runSlot('1, {N{4'h7}}, d, 1'b1, "R9");

    // sweep over occupancy and tag patterns
    for (int t = 0; t < 400; t++) begin
      v = N'($urandom);
      if (t % 5 == 0) v = v & N'($urandom);
      for (int k = 0; k < N; k++) begin
        s[k*SEQ_W +: SEQ_W] = (t % 2 == 0) ? SEQ_W'($urandom % 3) : SEQ_W'($urandom);
        d[k*DATA_W +: DATA_W] = {4'(t), 4'(k)};
      end
      runSlot(v, s, d, (t % 7 == 3), (t % 7 == 3) ? "R9" : "R1");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule